// File: doc/BRIEF.md
# Two-Source Immediate Element Selector

This block is a datapath permutation stage. It builds a vector result from two 256-bit sources, A and B. The source vectors are cut into 128-bit groups. In every group, the lower half of the result is filled from A and the upper half from B. An 8-bit control immediate picks which element of the matching source group lands in each destination slot. Elements are either 32 or 64 bits wide, and the same immediate is applied to every group.

The operand-size input says how much of the result is live: one 128-bit group or both groups. Every result bit above the live size is forced to zero. A size code that is not supported raises an error flag and returns an all-zero result.

The result is registered, so it appears one clock after the inputs. All selections are taken from the sampled inputs before the result register is written. Because of this, the answer is still correct when the caller feeds the same vector to A and B, or when it writes the output back onto one of the sources.

Top module: `shuf2src_sel`

## Requirements
- R1: In 32-bit element mode (`elem_sel`=0), result elements 0 and 1 of each 128-bit group are A's elements of that group indexed by `imm[1:0]` and `imm[3:2]` (index 0 = bits [31:0] of the group).
- R2: In 32-bit element mode, result elements 2 and 3 of each group are B's elements of that group indexed by `imm[5:4]` and `imm[7:6]`.
- R3: In 64-bit element mode (`elem_sel`=1), result element 0 of each group is A's 64-bit element indexed by `imm[0]`, and result element 1 is B's element indexed by `imm[1]`. `imm[7:2]` have no effect on the result.
- R4: Each group indexes only its own 128 bits of A and B, and every group uses the same immediate.
- R5: With `size_sel`=2'b01 (128-bit), result bits [255:128] are zero. With `size_sel`=2'b10 (256-bit), both groups are live.
- R6: `size_sel`=2'b00 (64-bit request) and 2'b11 (reserved) are illegal. They set `err`=1 with a zero result. Legal codes give `err`=0.
- R7: `result` and `err` are registered one clock after the inputs. A synchronous active-low reset clears both.
- R8: Every selected element is copied at its full width, 32 or 64 bits, into its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 256 | Source A, feeds the low half of each group |
| src_b | input | 256 | Source B, feeds the high half of each group |
| imm | input | 8 | Control immediate with the selector fields |
| elem_sel | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| size_sel | input | 2 | 00 = 64-bit (illegal), 01 = 128-bit, 10 = 256-bit, 11 = reserved (illegal) |
| result | output | 256 | Selected vector, registered |
| err | output | 1 | Illegal operand size, registered |

## Verification
Two functions can meet in one cycle: upper-group selection and upper-bit clearing. A 128-bit request still drives real selections in group 1, and these must be discarded in the same cycle that group 0 is formed. The bench provokes this by sending identical sources and immediate twice, first at 256-bit size and then at 128-bit size. It expects the low group to match in both results and the high group to go from the modelled selection to zero. A second collision pairs an illegal size with non-trivial data, where the zero-on-error path has to override a live selection. The bench also aliases A and B to the same vector so that both halves read one source.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
   typedef enum logic {
      ELEM32 = 1'b0,
      ELEM64 = 1'b1
   } elem_mode_e;

   typedef enum logic [1:0] {
      OPSZ_64  = 2'b00,
      OPSZ_128 = 2'b01,
      OPSZ_256 = 2'b10,
      OPSZ_RSV = 2'b11
   } opsize_e;

   localparam int unsigned ELEM32_W = 32;
   localparam int unsigned ELEM64_W = 64;
endpackage

// File: rtl/shuf_group.sv
module shuf_group
   import shuf_pkg::*;
#(
   parameter int unsigned GRP_W = 128,
   parameter int unsigned IMM_W = 8
) (
   input  logic [GRP_W-1:0] grp_a,
   input  logic [GRP_W-1:0] grp_b,
   input  logic [IMM_W-1:0] imm,
   input  elem_mode_e       mode,
   output logic [GRP_W-1:0] grp_res
);
   localparam int unsigned N32   = GRP_W / ELEM32_W;
   localparam int unsigned N64   = GRP_W / ELEM64_W;
   localparam int unsigned I32_W = $clog2(N32);
   localparam int unsigned I64_W = (N64 > 1) ? $clog2(N64) : 1;
   localparam int unsigned H32   = N32 / 2;
   localparam int unsigned H64   = N64 / 2;

   initial begin
      assert (GRP_W % ELEM64_W == 0 && N64 >= 2)
         else $error("shuf_group: GRP_W must hold at least two 64-bit elements");
      assert (N32 * I32_W <= IMM_W)
         else $error("shuf_group: immediate too narrow for 32-bit selectors");
      assert (N64 * I64_W <= IMM_W)
         else $error("shuf_group: immediate too narrow for 64-bit selectors");
   end

   logic [ELEM32_W-1:0] a32 [N32];
   logic [ELEM32_W-1:0] b32 [N32];
   logic [ELEM64_W-1:0] a64 [N64];
   logic [ELEM64_W-1:0] b64 [N64];
   logic [GRP_W-1:0]    res32;
   logic [GRP_W-1:0]    res64;

   for (genvar e = 0; e < N32; e++) begin : g_unpack32
      assign a32[e] = grp_a[e*ELEM32_W +: ELEM32_W];
      assign b32[e] = grp_b[e*ELEM32_W +: ELEM32_W];
   end
   for (genvar e = 0; e < N64; e++) begin : g_unpack64
      assign a64[e] = grp_a[e*ELEM64_W +: ELEM64_W];
      assign b64[e] = grp_b[e*ELEM64_W +: ELEM64_W];
   end

   // 32-bit path: low slots draw from A, high slots from B
   for (genvar k = 0; k < N32; k++) begin : g_slot32
      logic [I32_W-1:0] idx;
      assign idx = imm[k*I32_W +: I32_W];
      if (k < H32) begin : g_from_a
         assign res32[k*ELEM32_W +: ELEM32_W] = a32[idx];
      end else begin : g_from_b
         assign res32[k*ELEM32_W +: ELEM32_W] = b32[idx];
      end
   end

   // 64-bit path: one selector bit per slot
   for (genvar k = 0; k < N64; k++) begin : g_slot64
      logic [I64_W-1:0] idx;
      assign idx = imm[k*I64_W +: I64_W];
      if (k < H64) begin : g_from_a
         assign res64[k*ELEM64_W +: ELEM64_W] = a64[idx];
      end else begin : g_from_b
         assign res64[k*ELEM64_W +: ELEM64_W] = b64[idx];
      end
   end

   assign grp_res = (mode == ELEM64) ? res64 : res32;

   function automatic logic hit32(input logic [ELEM32_W-1:0] v,
                                  input logic [GRP_W-1:0] vec);
      logic h = 1'b0;
      for (int i = 0; i < int'(N32); i++)
         if (vec[i*ELEM32_W +: ELEM32_W] == v) h = 1'b1;
      return h;
   endfunction

   function automatic logic hit64(input logic [ELEM64_W-1:0] v,
                                  input logic [GRP_W-1:0] vec);
      logic h = 1'b0;
      for (int i = 0; i < int'(N64); i++)
         if (vec[i*ELEM64_W +: ELEM64_W] == v) h = 1'b1;
      return h;
   endfunction

   always_comb begin
      if (mode == ELEM32) begin
         assert_lo_from_a_R1: assert (hit32(grp_res[ELEM32_W-1:0], grp_a))
            else $error("R1: slot 0 not an element of A");
         assert_hi_from_b_R2: assert (hit32(grp_res[GRP_W-1 -: ELEM32_W], grp_b))
            else $error("R2: top slot not an element of B");
      end else begin
         assert_wide_b_R3: assert (hit64(grp_res[GRP_W-1 -: ELEM64_W], grp_b))
            else $error("R3: top 64-bit slot not an element of B");
      end
   end
endmodule

// File: rtl/shuf_span.sv
module shuf_span
   import shuf_pkg::*;
#(
   parameter int unsigned VEC_W = 256,
   parameter int unsigned GRP_W = 128
) (
   input  opsize_e                 size,
   output logic [VEC_W/GRP_W-1:0]  grp_keep,
   output logic                    illegal
);
   localparam int unsigned NGRP = VEC_W / GRP_W;

   initial begin
      assert (VEC_W % GRP_W == 0 && NGRP >= 1)
         else $error("shuf_span: VEC_W must be a multiple of GRP_W");
   end

   int unsigned live_bits;

   always_comb begin
      illegal   = 1'b0;
      live_bits = 0;
      case (size)
         OPSZ_128: live_bits = 128;
         OPSZ_256: live_bits = 256;
         default:  illegal   = 1'b1;
      endcase
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_keep
      assign grp_keep[g] = !illegal && ((g + 1) * GRP_W <= live_bits);
   end
endmodule

// File: rtl/shuf2src_sel.sv
module shuf2src_sel
   import shuf_pkg::*;
#(
   parameter int unsigned VEC_W = 256,
   parameter int unsigned GRP_W = 128,
   parameter int unsigned IMM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [IMM_W-1:0] imm,
   input  logic             elem_sel,
   input  logic [1:0]       size_sel,
   output logic [VEC_W-1:0] result,
   output logic             err
);
   localparam int unsigned NGRP = VEC_W / GRP_W;

   initial begin
      assert (NGRP >= 2)
         else $error("shuf2src_sel: need at least two groups");
   end

   elem_mode_e       mode;
   opsize_e          size;
   logic [NGRP-1:0]  grp_keep;
   logic             illegal;
   logic [VEC_W-1:0] sel_vec;
   logic [VEC_W-1:0] res_d;

   assign mode = elem_mode_e'(elem_sel);
   assign size = opsize_e'(size_sel);

   shuf_span #(.VEC_W(VEC_W), .GRP_W(GRP_W)) u_span (
      .size     (size),
      .grp_keep (grp_keep),
      .illegal  (illegal)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      shuf_group #(.GRP_W(GRP_W), .IMM_W(IMM_W)) u_group (
         .grp_a   (src_a[g*GRP_W +: GRP_W]),
         .grp_b   (src_b[g*GRP_W +: GRP_W]),
         .imm     (imm),
         .mode    (mode),
         .grp_res (sel_vec[g*GRP_W +: GRP_W])
      );
      assign res_d[g*GRP_W +: GRP_W] = grp_keep[g] ? sel_vec[g*GRP_W +: GRP_W] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         err    <= 1'b0;
      end else begin
         result <= res_d;
         err    <= illegal;
      end
   end

   assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (result == '0))
      else $error("R6: result not zero under error");

   assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (size_sel == 2'b01 || size_sel == 2'b10) |=> !err)
      else $error("R6: error raised for legal size");

   assert_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (size_sel == 2'b01) |=> (result[VEC_W-1:GRP_W] == '0))
      else $error("R5: bits above 128 not cleared");
endmodule

// File: tb/test_shuf2src_sel.sv
module test_shuf2src_sel;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] src_a = '0;
   logic [255:0] src_b = '0;
   logic [7:0]   imm = '0;
   logic         elem_sel = 1'b0;
   logic [1:0]   size_sel = 2'b10;
   logic [255:0] result;
   logic         err;
   int           n_run = 0;
   int           n_fail = 0;
   logic         done = 1'b0;

   always #4 clk = ~clk;

   shuf2src_sel i_shuf2src_sel (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .imm(imm),
      .elem_sel(elem_sel), .size_sel(size_sel), .result(result), .err(err)
   );

   function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                          input logic [7:0] im, input logic wide,
                                          input logic [1:0] sz);
      logic [255:0] r = '0;
      if (sz == 2'b00 || sz == 2'b11) return '0;
      for (int g = 0; g < 2; g++) begin
         if (!wide) begin
            for (int k = 0; k < 4; k++) begin
               int s = im[2*k +: 2];
               r[g*128 + k*32 +: 32] = (k < 2) ? a[g*128 + s*32 +: 32] : b[g*128 + s*32 +: 32];
            end
         end else begin
            r[g*128 +: 64]      = a[g*128 + im[0]*64 +: 64];
            r[g*128 + 64 +: 64] = b[g*128 + im[1]*64 +: 64];
         end
      end
      if (sz == 2'b01) r[255:128] = '0;
      return r;
   endfunction

   function automatic logic [255:0] pattern(input logic [3:0] tag);
      logic [255:0] v;
      for (int e = 0; e < 8; e++) v[e*32 +: 32] = {tag, 4'h0, 8'(e * 17 + 3), 16'hC0DE ^ 16'(e)};
      return v;
   endfunction

   task automatic check(input string req, input logic [255:0] exp_r, input logic exp_e);
      n_run++;
      if (result !== exp_r || err !== exp_e) begin
         n_fail++;
         $display("FAIL %s: result=%h err=%b expected result=%h err=%b", req, result, err, exp_r, exp_e);
      end
   endtask

   task automatic apply(input logic [255:0] a, input logic [255:0] b, input logic [7:0] im,
                        input logic wide, input logic [1:0] sz);
      @(negedge clk);
      src_a = a; src_b = b; imm = im; elem_sel = wide; size_sel = sz;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R7 reset", '0, 1'b0);
   endtask

   task automatic t_mode32;
      logic [255:0] a = pattern(4'hA), b = pattern(4'hB);
      logic [7:0] ims [4] = '{8'hE4, 8'h1B, 8'h00, 8'hB1};
      for (int i = 0; i < 4; i++) begin
         apply(a, b, ims[i], 1'b0, 2'b10);
         check("R1 R2 R8 32-bit select", model(a, b, ims[i], 1'b0, 2'b10), 1'b0);
      end
   endtask

   task automatic t_mode64;
      logic [255:0] a = pattern(4'h5), b = pattern(4'h9);
      for (int i = 0; i < 4; i++) begin
         apply(a, b, 8'(i), 1'b1, 2'b10);
         check("R3 R8 64-bit select", model(a, b, 8'(i), 1'b1, 2'b10), 1'b0);
      end
      apply(a, b, 8'hFE, 1'b1, 2'b10);
      check("R3 high imm bits ignored", model(a, b, 8'h02, 1'b1, 2'b10), 1'b0);
   endtask

   task automatic t_groups;
      logic [255:0] a = {128'h0, pattern(4'h3)[127:0]};
      logic [255:0] b = {pattern(4'h7)[255:128], 128'h0};
      apply(a, b, 8'h4E, 1'b0, 2'b10);
      check("R4 group-local selection", model(a, b, 8'h4E, 1'b0, 2'b10), 1'b0);
   endtask

   task automatic t_size_collide;
      logic [255:0] a = pattern(4'h1), b = pattern(4'h2);
      apply(a, b, 8'h9C, 1'b0, 2'b10);
      check("R5 256-bit both groups live", model(a, b, 8'h9C, 1'b0, 2'b10), 1'b0);
      apply(a, b, 8'h9C, 1'b0, 2'b01);
      check("R5 128-bit upper cleared", {128'h0, model(a, b, 8'h9C, 1'b0, 2'b10)[127:0]}, 1'b0);
      apply(a, b, 8'h03, 1'b1, 2'b01);
      check("R5 128-bit 64-bit mode", model(a, b, 8'h03, 1'b1, 2'b01), 1'b0);
   endtask

   task automatic t_illegal;
      logic [255:0] a = pattern(4'hC), b = pattern(4'hD);
      apply(a, b, 8'h5A, 1'b0, 2'b00);
      check("R6 64-bit size illegal", '0, 1'b1);
      apply(a, b, 8'h5A, 1'b1, 2'b11);
      check("R6 reserved size illegal", '0, 1'b1);
      apply(a, b, 8'h5A, 1'b0, 2'b10);
      check("R6 error clears on legal size", model(a, b, 8'h5A, 1'b0, 2'b10), 1'b0);
   endtask

   task automatic t_alias;
      logic [255:0] v = pattern(4'hF);
      apply(v, v, 8'h27, 1'b0, 2'b10);
      check("R7 aliased sources", model(v, v, 8'h27, 1'b0, 2'b10), 1'b0);
   endtask

   task automatic t_latency;
      logic [255:0] a = pattern(4'h4), b = pattern(4'h6);
      @(negedge clk);
      src_a = a; src_b = b; imm = 8'hD8; elem_sel = 1'b0; size_sel = 2'b10;
      @(posedge clk);
      #1;
      check("R7 one-cycle latency", model(a, b, 8'hD8, 1'b0, 2'b10), 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_mode32();
      t_mode64();
      t_groups();
      t_size_collide();
      t_illegal();
      t_alias();
      t_latency();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R7 watchdog: actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule